// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block is the software-facing side of an SMBus host controller. A processor reaches it through byte-wide register reads and writes on a 6-bit offset. It holds a command byte, a target address byte carrying the read flag, two data bytes and a 32-entry byte buffer for block transfers. Writing the control register with its start bit set decodes a protocol code. For a legal code it raises one transaction request towards an external bus engine. For an illegal code it flags an error and raises no request.

Requests and responses use a valid/ready handshake. The request carries the protocol code, the 7-bit device address, the read flag, the command byte and both data bytes. For block transfers the engine reads and fills the shared buffer through a side port while the block is busy. When the response is accepted, the returned read bytes are stored, busy drops and a done flag rises. Software reaches the buffer through one data port. That port uses an auto-incrementing index which wraps at the buffer depth.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register reads 0 (status, control, command, address, data0, data1 and block port), req_valid is 0 and the buffer holds zeros.
- R2: The command (0x03), address (0x04), data0 (0x05) and data1 (0x06) registers read back the last byte written. Offsets 0x01 and 0x08 to 0x3f read 0, and writes to them change nothing.
- R3: A write to control (0x02) stores the byte. A read of control returns only bits 4:0, with bits 7:5 reading 0, and resets the block index to 0.
- R4: A control write with bit 6 set, while not busy, starts a transaction for protocol codes 0, 1, 2, 3 and 5 in bits 4:2. From the next cycle req_valid is high with req_proto = code, req_dev = address bits 7:1, req_read = address bit 0, and the command, data0 and data1 bytes. Status bit 0 (busy) is set. The request holds stable until req_ready.
- R5: Protocol codes 4, 6 and 7 set status bit 2 (error), raise no request and leave busy at 0.
- R6: rsp_ready is high only while busy and after the request has been accepted. On a response handshake, busy clears and status bit 1 (done) is set.
- R7: On completion of a read (read flag 1): codes 1 and 2 store rsp_data0 into data0; code 3 stores rsp_data0 into data0 (low byte) and rsp_data1 into data1 (high byte); code 5 stores the returned count rsp_data0 into data0. Writes and code 0 leave data0 and data1 unchanged.
- R8: Each read or write of the block port (0x07) accesses buffer[index] and then increments the index, which wraps from 31 to 0.
- R9: Any write to status (0x00) clears the done and error bits, whatever the written value, and resets the index to 0. Busy is not affected.
- R10: While busy, writes to control, command, address, data0, data1 and the block port are ignored, so a second start request is ignored.
- R11: blk_rdata always shows buffer[blk_raddr]. blk_we writes blk_wdata into buffer[blk_waddr] only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects on the index) |
| addr | input | 6 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of rd_en |
| req_valid | output | 1 | Transaction request valid |
| req_ready | input | 1 | Engine accepts request |
| req_proto | output | 3 | Protocol code |
| req_dev | output | 7 | 7-bit device address |
| req_read | output | 1 | Read flag |
| req_cmd | output | 8 | Command byte (send-byte payload) |
| req_data0 | output | 8 | Data0 (low byte, block length) |
| req_data1 | output | 8 | Data1 (high byte) |
| rsp_valid | input | 1 | Engine response valid |
| rsp_ready | output | 1 | Block accepts response |
| rsp_data0 | input | 8 | Returned byte, low byte or block count |
| rsp_data1 | input | 8 | Returned high byte |
| blk_raddr | input | 5 | Engine buffer read index |
| blk_rdata | output | 8 | Buffer byte at blk_raddr |
| blk_we | input | 1 | Engine buffer write strobe |
| blk_waddr | input | 5 | Engine buffer write index |
| blk_wdata | input | 8 | Engine buffer write data |

## Verification
A corrupt block index shows on the very next block-port read as a byte from the wrong buffer slot. Because the bench mixes status writes and control reads among these accesses, an index that fails to reset shows within one access. A wrong busy or pending state shows on the request and response handshake in the same cycle: a missing or repeated req_valid, or rsp_ready at the wrong time. A wrong stored response or a missing error flag shows on the following status or data-register read.

// File: rtl/smb_host_regs.sv
module smb_host_regs #(
  parameter int BUF_DEPTH = 32,
  parameter int ADDR_W    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   rdata,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [2:0]                   req_proto,
  output logic [6:0]                   req_dev,
  output logic                         req_read,
  output logic [7:0]                   req_cmd,
  output logic [7:0]                   req_data0,
  output logic [7:0]                   req_data1,
  input  logic                         rsp_valid,
  output logic                         rsp_ready,
  input  logic [7:0]                   rsp_data0,
  input  logic [7:0]                   rsp_data1,
  input  logic [$clog2(BUF_DEPTH)-1:0] blk_raddr,
  output logic [7:0]                   blk_rdata,
  input  logic                         blk_we,
  input  logic [$clog2(BUF_DEPTH)-1:0] blk_waddr,
  input  logic [7:0]                   blk_wdata
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_ADR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_D0   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFS_D1   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_BLK  = ADDR_W'(7);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(BUF_DEPTH - 1);

  logic             busy, done_q, err_q, req_q;
  logic [7:0]       ctl, cmd, adr, d0, d1;
  logic [IDX_W-1:0] idx;
  logic [7:0]       mem [BUF_DEPTH];

  wire sw_wr    = wr_en && !busy;
  wire wr_stat  = wr_en && addr == OFS_STAT;
  wire start    = sw_wr && addr == OFS_CTL && wdata[6];
  wire code_ok  = wdata[4:2] <= 3'd3 || wdata[4:2] == 3'd5;
  wire rsp_fire = rsp_valid && rsp_ready;
  wire blk_acc  = (rd_en || sw_wr) && addr == OFS_BLK;
  wire idx_clr  = wr_stat || (rd_en && addr == OFS_CTL);
  wire rd_done  = rsp_fire && adr[0];

  assign req_valid = req_q;
  assign req_proto = ctl[4:2];
  assign req_dev   = adr[7:1];
  assign req_read  = adr[0];
  assign req_cmd   = cmd;
  assign req_data0 = d0;
  assign req_data1 = d1;
  assign rsp_ready = busy && !req_q;
  assign blk_rdata = mem[blk_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; req_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (start) begin
        if (code_ok) begin
          busy  <= 1'b1;
          req_q <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (req_q && req_ready) req_q <= 1'b0;
      if (rsp_fire) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; cmd <= '0; adr <= '0; d0 <= '0; d1 <= '0;
    end else begin
      if (sw_wr && addr == OFS_CTL) ctl <= wdata;
      if (sw_wr && addr == OFS_CMD) cmd <= wdata;
      if (sw_wr && addr == OFS_ADR) adr <= wdata;
      if (sw_wr && addr == OFS_D0)  d0  <= wdata;
      if (sw_wr && addr == OFS_D1)  d1  <= wdata;
      if (rd_done && ctl[4:2] != 3'd0) d0 <= rsp_data0;
      if (rd_done && ctl[4:2] == 3'd3) d1 <= rsp_data1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              idx <= '0;
    else if (idx_clr)        idx <= '0;
    else if (blk_acc)        idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
  end

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (busy && blk_we && blk_waddr == IDX_W'(g))
        mem[g] <= blk_wdata;
      else if (sw_wr && addr == OFS_BLK && idx == IDX_W'(g))
        mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        OFS_STAT: rdata = {5'd0, err_q, done_q, busy};
        OFS_CTL:  rdata = {3'd0, ctl[4:0]};
        OFS_CMD:  rdata = cmd;
        OFS_ADR:  rdata = adr;
        OFS_D0:   rdata = d0;
        OFS_D1:   rdata = d1;
        OFS_BLK:  rdata = mem[idx];
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int BUF_DEPTH = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic [5:0]                   addr,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [2:0]                   req_proto,
  input logic [6:0]                   req_dev,
  input logic                         req_read,
  input logic [7:0]                   req_cmd,
  input logic [7:0]                   req_data0,
  input logic [7:0]                   req_data1,
  input logic                         rsp_valid,
  input logic                         rsp_ready,
  input logic                         busy,
  input logic                         done_q,
  input logic                         err_q,
  input logic [$clog2(BUF_DEPTH)-1:0] idx
);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_proto) && $stable(req_dev)
      && $stable(req_read) && $stable(req_cmd) && $stable(req_data0) && $stable(req_data1));

  a_r4_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  a_r5_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_proto <= 3'd3 || req_proto == 3'd5));

  a_r6_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !busy && done_q);

  a_r8_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr == 6'd7 && idx == ($clog2(BUF_DEPTH))'(BUF_DEPTH - 1) |=> idx == '0);

  a_r9_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 6'd0 |=> idx == '0 && !err_q);

  a_r10_busy_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && addr == 6'd2 |=> $stable(req_proto));
endmodule

bind smb_host_regs smb_host_regs_chk #(.BUF_DEPTH(BUF_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .req_valid(req_valid), .req_ready(req_ready), .req_proto(req_proto),
  .req_dev(req_dev), .req_read(req_read), .req_cmd(req_cmd),
  .req_data0(req_data0), .req_data1(req_data1), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .busy(busy), .done_q(done_q), .err_q(err_q), .idx(idx)
);

// File: tb/smb_host_regs_tb_top.sv
module smb_host_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [5:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic req_valid, req_ready = 0, req_read;
  logic [2:0] req_proto;
  logic [6:0] req_dev;
  logic [7:0] req_cmd, req_data0, req_data1;
  logic rsp_valid = 0, rsp_ready;
  logic [7:0] rsp_data0 = 0, rsp_data1 = 0;
  logic [4:0] blk_raddr = 0, blk_waddr = 0;
  logic [7:0] blk_rdata, blk_wdata = 0;
  logic blk_we = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_ctl, m_cmd, m_adr, m_d0, m_d1;
  logic [7:0] m_buf [32];
  logic [4:0] m_idx;
  logic m_busy, m_done, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_proto(req_proto), .req_dev(req_dev), .req_read(req_read),
    .req_cmd(req_cmd), .req_data0(req_data0), .req_data1(req_data1),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data0(rsp_data0),
    .rsp_data1(rsp_data1), .blk_raddr(blk_raddr), .blk_rdata(blk_rdata),
    .blk_we(blk_we), .blk_waddr(blk_waddr), .blk_wdata(blk_wdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    case (a)
      6'd0: return {5'd0, m_err, m_done, m_busy};
      6'd2: return {3'd0, m_ctl[4:0]};
      6'd3: return m_cmd;
      6'd4: return m_adr;
      6'd5: return m_d0;
      6'd6: return m_d1;
      6'd7: return m_buf[m_idx];
      default: return 8'd0;
    endcase
  endfunction

  task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 6'd0) begin m_done = 0; m_err = 0; m_idx = 0; end
    else if (!m_busy) begin
      case (a)
        6'd2: m_ctl = d;
        6'd3: m_cmd = d;
        6'd4: m_adr = d;
        6'd5: m_d0 = d;
        6'd6: m_d1 = d;
        6'd7: begin m_buf[m_idx] = d; m_idx = m_idx + 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic do_rd(input logic [5:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1; addr = a;
    #1;
    e = exp_rd(a);
    check(rdata === e, req, rdata, e);
    @(negedge clk);
    rd_en = 0;
    if (a == 6'd2) m_idx = 0;
    if (a == 6'd7) m_idx = m_idx + 1'b1;
  endtask

  task automatic xact(input logic [2:0] code, input logic [7:0] adrv, input logic [7:0] cmdv,
                      input logic [7:0] d0v, input logic [7:0] d1v);
    logic [7:0] r0, r1;
    int n;
    do_wr(6'd3, cmdv); do_wr(6'd4, adrv); do_wr(6'd5, d0v); do_wr(6'd6, d1v);
    do_wr(6'd2, 8'h40 | {3'd0, code, 2'd0});
    #1;
    if (code == 3'd4 || code >= 3'd6) begin
      m_err = 1;
      check(req_valid === 1'b0, "R5 no request on bad code", req_valid, 0);
      do_rd(6'd0, "R5 error flag set, busy clear");
      return;
    end
    m_busy = 1;
    check(req_valid === 1'b1, "R4 req_valid after start", req_valid, 1);
    check(req_proto === code && req_dev === m_adr[7:1] && req_read === m_adr[0],
          "R4 request code/device/read", {req_proto, req_dev, req_read}, {code, m_adr[7:1], m_adr[0]});
    check(req_cmd === m_cmd && req_data0 === m_d0 && req_data1 === m_d1,
          "R4 request bytes", {req_cmd, req_data0, req_data1}, {m_cmd, m_d0, m_d1});
    check(rsp_ready === 1'b0, "R6 rsp_ready low before request accepted", rsp_ready, 0);
    do_rd(6'd0, "R4 busy bit while outstanding");
    do_wr(6'd3, ~cmdv);
    do_wr(6'd2, 8'h40 | {3'd0, code ^ 3'd1, 2'd0});
    #1;
    check(req_valid === 1'b1 && req_proto === code, "R10 start while busy ignored", req_proto, code);
    do_rd(6'd3, "R10 command write while busy ignored");
    @(negedge clk); req_ready = 1;
    @(negedge clk); req_ready = 0;
    #1;
    check(req_valid === 1'b0, "R4 request drops after ready", req_valid, 0);
    if (code == 3'd5 && !m_adr[0]) begin
      n = (m_d0 > 32) ? 32 : int'(m_d0);
      for (int k = 0; k < n; k++) begin
        blk_raddr = 5'(k); #1;
        check(blk_rdata === m_buf[k], "R11 engine buffer read", blk_rdata, m_buf[k]);
      end
    end
    r0 = 8'($urandom); r1 = 8'($urandom);
    if (code == 3'd5 && m_adr[0]) begin
      r0 = 8'($urandom_range(0, 32));
      for (int k = 0; k < int'(r0); k++) begin
        @(negedge clk);
        blk_we = 1; blk_waddr = 5'(k); blk_wdata = 8'($urandom);
        m_buf[k] = blk_wdata;
      end
      @(negedge clk); blk_we = 0;
    end
    @(negedge clk);
    rsp_valid = 1; rsp_data0 = r0; rsp_data1 = r1;
    #1;
    check(rsp_ready === 1'b1, "R6 rsp_ready while waiting", rsp_ready, 1);
    @(negedge clk);
    rsp_valid = 0;
    m_busy = 0; m_done = 1;
    if (m_adr[0] && code != 3'd0) m_d0 = r0;
    if (m_adr[0] && code == 3'd3) m_d1 = r1;
    do_rd(6'd0, "R6 done set, busy clear");
    do_rd(6'd5, "R7 data0 after completion");
    do_rd(6'd6, "R7 data1 after completion");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_ctl = 0; m_cmd = 0; m_adr = 0; m_d0 = 0; m_d1 = 0; m_idx = 0;
    m_busy = 0; m_done = 0; m_err = 0;
    for (int k = 0; k < 32; k++) m_buf[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(req_valid === 1'b0, "R1 req_valid after reset", req_valid, 0);
    for (int a = 0; a < 8; a++) do_rd(6'(a), "R1 register reset value");
    do_wr(6'd2, 8'd0);
    blk_raddr = 5'd31; #1;
    check(blk_rdata === 8'd0, "R1 buffer reset zero", blk_rdata, 0);

    for (int k = 0; k < 33; k++) do_wr(6'd7, 8'(k * 7 + 1));
    do_wr(6'd0, 8'hff);
    for (int k = 0; k < 34; k++) do_rd(6'd7, "R8 block port sequence and wrap");
    do_rd(6'd2, "R3 control read masks high bits");
    do_rd(6'd7, "R3 control read resets index");
    do_wr(6'd2, 8'hbf);
    do_rd(6'd2, "R3 control stores byte, reads low 5 bits");
    do_wr(6'd9, 8'h55);
    do_rd(6'd9, "R2 unmapped offset reads zero");
    do_wr(6'd1, 8'haa);
    do_rd(6'd1, "R2 offset 1 reads zero");

    @(negedge clk); blk_we = 1; blk_waddr = 5'd3; blk_wdata = 8'h99;
    @(negedge clk); blk_we = 0; blk_raddr = 5'd3; #1;
    check(blk_rdata === m_buf[3], "R11 engine write ignored when idle", blk_rdata, m_buf[3]);

    xact(3'd3, 8'ha5, 8'h12, 8'h34, 8'h56);
    xact(3'd3, 8'ha4, 8'h12, 8'h34, 8'h56);
    xact(3'd5, 8'h20, 8'h01, 8'd5, 8'h00);
    xact(3'd5, 8'h21, 8'h02, 8'd0, 8'h00);
    xact(3'd6, 8'h11, 8'h00, 8'h00, 8'h00);
    do_wr(6'd0, 8'h00);
    do_rd(6'd0, "R9 status write clears done and error");
    xact(3'd0, 8'h31, 8'h00, 8'h77, 8'h88);
    xact(3'd4, 8'h31, 8'h00, 8'h77, 8'h88);

    for (int it = 0; it < 500; it++) begin
      int op;
      logic [5:0] ra;
      op = $urandom_range(0, 9);
      ra = 6'($urandom_range(3, 7));
      case (op)
        0, 1: do_wr(ra, 8'($urandom));
        2, 3: do_rd(ra, "R2 R8 random register read");
        4: do_rd(6'd2, "R3 random control read");
        5: do_wr(6'd0, 8'($urandom));
        6: do_wr(6'($urandom_range(8, 63)), 8'($urandom));
        7: do_wr(6'd2, 8'($urandom) & 8'hbf);
        8: do_rd(6'd0, "R9 random status read");
        default: xact(3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      endcase
    end
    for (int a = 0; a < 8; a++) do_rd(6'(a), "R2 final register sweep");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule